// File: doc/BRIEF.md
# Dual-Order Mesh Route Selector

This block computes routes for one router of a two-dimensional mesh network-on-chip. Each packet travels under one of two dimension orders. Under X-first order it moves horizontally until its column matches the destination, then vertically. Under Y-first order it moves vertically first, then horizontally. The order is picked once, at the router where the packet enters the network. The block sums externally supplied per-node load scores along each candidate path and takes the cheaper one. That score set reflects topology and long-term traffic, and the block reads it live, so the choice can change from cycle to cycle. The chosen order goes back into the header as a single bit. Every later router obeys that bit and does not decide again.

The head flit's destination, its header order bit and an inject flag are captured in a register. From that register the output port, the order to write into the header and the virtual-channel class are derived combinationally. The two orders use disjoint virtual-channel classes, so their channel dependencies cannot form a cycle. Buffering, switch allocation, credit handling and the computation of the load scores are outside this block.

Top module: `mesh_route_sel`

## Requirements
- R1: A flit presented with `flit_valid_i` and `flit_head_i` both high produces `route_valid_o` high in the following cycle only. Body flits and idle cycles leave `route_valid_o` low.
- R2: Under X-first order (order bit 0), the port is east while the destination X exceeds the current X, and west while it is smaller. Once X matches, the port is north if the destination Y is larger and south if it is smaller.
- R3: Under Y-first order (order bit 1), Y is resolved first (north/south), then X (east/west). East means increasing X and north means increasing Y.
- R4: When the destination equals the router's own coordinates, the port is local under either order. Port codes are local=0, east=1, west=2, north=3, south=4.
- R5: For an injected packet (`flit_inject_i`=1), the cost of an order is the sum of the load scores of every node on its path, source and destination included. The load score of node (x,y) sits at `node_load_i[(y*MESH_X+x)*LOAD_W +: LOAD_W]`. Y-first is chosen only when its cost is strictly lower.
- R6: An injected packet whose destination shares the current row or column, or whose two costs are equal, is given X-first order.
- R7: A packet in transit (`flit_inject_i`=0) keeps the order bit carried in its header, and the load scores have no effect on its port or order.
- R8: `route_order_o` is the bit to write into the header, and `route_vc_o` is the virtual-channel class: 0 for X-first and 1 for Y-first.
- R9: While a head is held in the register, a change of `node_load_i` changes the injection decision in the same cycle, with no clock edge in between.
- R10: While `rst_n` is low, `route_valid_o` is low, and asserting reset clears it immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| here_x_i | input | COORD_W | X coordinate of this router |
| here_y_i | input | COORD_W | Y coordinate of this router |
| flit_valid_i | input | 1 | Flit present this cycle |
| flit_head_i | input | 1 | Flit is a head flit |
| flit_inject_i | input | 1 | Packet enters the network at this router |
| flit_order_i | input | 1 | Order bit carried in the header |
| flit_dst_x_i | input | COORD_W | Destination X from the header |
| flit_dst_y_i | input | COORD_W | Destination Y from the header |
| node_load_i | input | MESH_X*MESH_Y*LOAD_W | Load score of every node |
| route_valid_o | output | 1 | Route result valid for a head flit |
| route_port_o | output | 3 | Output port code |
| route_order_o | output | 1 | Order bit to write into the header |
| route_vc_o | output | 1 | Virtual-channel class |

## Verification
The bench places a heavy node on only one of the two candidate paths and checks that the cheaper order is chosen. A design that compared only the two corner nodes, or swapped the comparison, would pick the loaded path. Shared-row, shared-column, tie and own-node destinations are included, because a design that ignored the tie rule would emit Y-first there, or would send a packet for itself out of a mesh port. Transit packets are routed under loads that favour the opposite order, which exposes any router that re-decides mid-path. Separate tests cover body flits (a spurious valid), a load change while a head is held (a decision latched at capture), and a mid-packet reset.

// File: rtl/route_pkg.sv
package route_pkg;
  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;

  typedef enum logic {
    ORD_XFIRST = 1'b0,
    ORD_YFIRST = 1'b1
  } order_e;
endpackage

// File: rtl/mesh_path_cost.sv
module mesh_path_cost #(
  parameter int MESH_X  = 4,
  parameter int MESH_Y  = 4,
  parameter int COORD_W = 2,
  parameter int LOAD_W  = 4,
  parameter int SUM_W   = 9
) (
  input  logic [COORD_W-1:0]               src_x_i,
  input  logic [COORD_W-1:0]               src_y_i,
  input  logic [COORD_W-1:0]               dst_x_i,
  input  logic [COORD_W-1:0]               dst_y_i,
  input  logic [MESH_X*MESH_Y*LOAD_W-1:0]  node_load_i,
  output logic [SUM_W-1:0]                 cost_xy_o,
  output logic [SUM_W-1:0]                 cost_yx_o
);
  localparam int NODES = MESH_X * MESH_Y;

  logic [LOAD_W-1:0] load_arr [NODES];

  for (genvar n = 0; n < NODES; n++) begin : g_unpack
    assign load_arr[n] = node_load_i[n*LOAD_W +: LOAD_W];
  end

  // Sum of load scores over the nodes visited by each dimension order.
  always_comb begin
    int sx, sy, dx, dy, lx, hx, ly, hy;
    logic on_xy, on_yx;
    sx = int'(src_x_i);
    sy = int'(src_y_i);
    dx = int'(dst_x_i);
    dy = int'(dst_y_i);
    lx = (sx < dx) ? sx : dx;
    hx = (sx < dx) ? dx : sx;
    ly = (sy < dy) ? sy : dy;
    hy = (sy < dy) ? dy : sy;
    cost_xy_o = '0;
    cost_yx_o = '0;
    for (int y = 0; y < MESH_Y; y++) begin
      for (int x = 0; x < MESH_X; x++) begin
        on_xy = ((y == sy) && (x >= lx) && (x <= hx)) ||
                ((x == dx) && (y >= ly) && (y <= hy));
        on_yx = ((x == sx) && (y >= ly) && (y <= hy)) ||
                ((y == dy) && (x >= lx) && (x <= hx));
        if (on_xy) cost_xy_o = cost_xy_o + SUM_W'(load_arr[y*MESH_X+x]);
        if (on_yx) cost_yx_o = cost_yx_o + SUM_W'(load_arr[y*MESH_X+x]);
      end
    end
  end
endmodule

// File: rtl/order_pick.sv
module order_pick #(
  parameter int SUM_W = 9
) (
  input  logic [SUM_W-1:0] cost_xy_i,
  input  logic [SUM_W-1:0] cost_yx_i,
  input  logic             same_line_i,
  output route_pkg::order_e order_o
);
  import route_pkg::*;

  // X-first wins ties and single-dimension routes.
  always_comb begin
    if (!same_line_i && (cost_yx_i < cost_xy_i)) order_o = ORD_YFIRST;
    else                                          order_o = ORD_XFIRST;
  end
endmodule

// File: rtl/dor_port_calc.sv
module dor_port_calc #(
  parameter int COORD_W = 2
) (
  input  logic [COORD_W-1:0] cur_x_i,
  input  logic [COORD_W-1:0] cur_y_i,
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] dst_y_i,
  input  route_pkg::order_e  order_i,
  output route_pkg::port_e   port_o
);
  import route_pkg::*;

  port_e step_x, step_y;

  always_comb begin
    if      (dst_x_i > cur_x_i) step_x = PORT_EAST;
    else if (dst_x_i < cur_x_i) step_x = PORT_WEST;
    else                        step_x = PORT_LOCAL;

    if      (dst_y_i > cur_y_i) step_y = PORT_NORTH;
    else if (dst_y_i < cur_y_i) step_y = PORT_SOUTH;
    else                        step_y = PORT_LOCAL;

    if (order_i == ORD_XFIRST) port_o = (step_x != PORT_LOCAL) ? step_x : step_y;
    else                       port_o = (step_y != PORT_LOCAL) ? step_y : step_x;
  end
endmodule

// File: rtl/mesh_route_sel.sv
module mesh_route_sel #(
  parameter int MESH_X  = 4,
  parameter int MESH_Y  = 4,
  parameter int COORD_W = 2,
  parameter int LOAD_W  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [COORD_W-1:0]                here_x_i,
  input  logic [COORD_W-1:0]                here_y_i,
  input  logic                              flit_valid_i,
  input  logic                              flit_head_i,
  input  logic                              flit_inject_i,
  input  logic                              flit_order_i,
  input  logic [COORD_W-1:0]                flit_dst_x_i,
  input  logic [COORD_W-1:0]                flit_dst_y_i,
  input  logic [MESH_X*MESH_Y*LOAD_W-1:0]   node_load_i,
  output logic                              route_valid_o,
  output logic [2:0]                        route_port_o,
  output logic                              route_order_o,
  output logic                              route_vc_o
);
  import route_pkg::*;

  localparam int NODES = MESH_X * MESH_Y;
  localparam int SUM_W = LOAD_W + $clog2(NODES) + 1;

  // Header register
  logic               head_vld_q, head_vld_d;
  logic               hdr_inject_q, hdr_inject_d;
  logic               hdr_order_q, hdr_order_d;
  logic [COORD_W-1:0] hdr_dx_q, hdr_dx_d;
  logic [COORD_W-1:0] hdr_dy_q, hdr_dy_d;
  logic               capture_en;

  assign capture_en = flit_valid_i && flit_head_i;

  always_comb begin
    head_vld_d   = capture_en;
    hdr_inject_d = hdr_inject_q;
    hdr_order_d  = hdr_order_q;
    hdr_dx_d     = hdr_dx_q;
    hdr_dy_d     = hdr_dy_q;
    if (capture_en) begin
      hdr_inject_d = flit_inject_i;
      hdr_order_d  = flit_order_i;
      hdr_dx_d     = flit_dst_x_i;
      hdr_dy_d     = flit_dst_y_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_vld_q   <= 1'b0;
      hdr_inject_q <= 1'b0;
      hdr_order_q  <= 1'b0;
      hdr_dx_q     <= '0;
      hdr_dy_q     <= '0;
    end else begin
      head_vld_q   <= head_vld_d;
      hdr_inject_q <= hdr_inject_d;
      hdr_order_q  <= hdr_order_d;
      hdr_dx_q     <= hdr_dx_d;
      hdr_dy_q     <= hdr_dy_d;
    end
  end

  // Order selection at injection
  logic [SUM_W-1:0] cost_xy, cost_yx;
  logic             same_line;
  order_e           picked_order, active_order;
  port_e            port_sel;

  mesh_path_cost #(
    .MESH_X(MESH_X), .MESH_Y(MESH_Y), .COORD_W(COORD_W),
    .LOAD_W(LOAD_W), .SUM_W(SUM_W)
  ) i_cost (
    .src_x_i     (here_x_i),
    .src_y_i     (here_y_i),
    .dst_x_i     (hdr_dx_q),
    .dst_y_i     (hdr_dy_q),
    .node_load_i (node_load_i),
    .cost_xy_o   (cost_xy),
    .cost_yx_o   (cost_yx)
  );

  assign same_line = (hdr_dx_q == here_x_i) || (hdr_dy_q == here_y_i);

  order_pick #(.SUM_W(SUM_W)) i_pick (
    .cost_xy_i   (cost_xy),
    .cost_yx_i   (cost_yx),
    .same_line_i (same_line),
    .order_o     (picked_order)
  );

  assign active_order = hdr_inject_q ? picked_order : order_e'(hdr_order_q);

  dor_port_calc #(.COORD_W(COORD_W)) i_port (
    .cur_x_i (here_x_i),
    .cur_y_i (here_y_i),
    .dst_x_i (hdr_dx_q),
    .dst_y_i (hdr_dy_q),
    .order_i (active_order),
    .port_o  (port_sel)
  );

  assign route_valid_o = head_vld_q;
  assign route_port_o  = port_sel;
  assign route_order_o = active_order;
  assign route_vc_o    = active_order;
endmodule

// File: rtl/mesh_route_sel_chk.sv
module mesh_route_sel_chk #(
  parameter int COORD_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [COORD_W-1:0] here_x_i,
  input logic [COORD_W-1:0] here_y_i,
  input logic               flit_valid_i,
  input logic               flit_head_i,
  input logic               flit_inject_i,
  input logic               flit_order_i,
  input logic [COORD_W-1:0] flit_dst_x_i,
  input logic [COORD_W-1:0] flit_dst_y_i,
  input logic               route_valid_o,
  input logic [2:0]         route_port_o,
  input logic               route_order_o
);
  p_valid_from_head_r1: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid_o |-> $past(flit_valid_i && flit_head_i));

  p_local_iff_home_r4: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid_o |-> ((route_port_o == 3'd0) ==
      (($past(flit_dst_x_i) == here_x_i) && ($past(flit_dst_y_i) == here_y_i))));

  p_east_minimal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid_o && route_port_o == 3'd1) |-> ($past(flit_dst_x_i) > here_x_i));

  p_west_minimal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid_o && route_port_o == 3'd2) |-> ($past(flit_dst_x_i) < here_x_i));

  p_line_xfirst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid_o && $past(flit_inject_i) &&
     (($past(flit_dst_x_i) == here_x_i) || ($past(flit_dst_y_i) == here_y_i)))
    |-> (route_order_o == 1'b0));

  p_transit_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid_o && !$past(flit_inject_i)) |-> (route_order_o == $past(flit_order_i)));

  p_port_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid_o |-> (route_port_o <= 3'd4));
endmodule

bind mesh_route_sel mesh_route_sel_chk #(.COORD_W(COORD_W)) i_chk (.*);

// File: tb/test_mesh_route_sel.sv
`timescale 1ns/1ps
module test_mesh_route_sel;
  localparam int MX = 4, MY = 4, CW = 2, LW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [CW-1:0]   here_x, here_y, dst_x, dst_y;
  logic            f_valid, f_head, f_inject, f_order;
  logic [MX*MY*LW-1:0] loads;
  logic            r_valid, r_order, r_vc;
  logic [2:0]      r_port;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  mesh_route_sel #(.MESH_X(MX), .MESH_Y(MY), .COORD_W(CW), .LOAD_W(LW)) i_mesh_route_sel (
    .clk(clk), .rst_n(rst_n), .here_x_i(here_x), .here_y_i(here_y),
    .flit_valid_i(f_valid), .flit_head_i(f_head), .flit_inject_i(f_inject),
    .flit_order_i(f_order), .flit_dst_x_i(dst_x), .flit_dst_y_i(dst_y),
    .node_load_i(loads), .route_valid_o(r_valid), .route_port_o(r_port),
    .route_order_o(r_order), .route_vc_o(r_vc));

  // Load pattern: every node scores 1, one hot node scores 15.
  function automatic logic [MX*MY*LW-1:0] hot_load(input int hot);
    logic [MX*MY*LW-1:0] v;
    for (int i = 0; i < MX*MY; i++) v[i*LW +: LW] = (i == hot) ? 4'd15 : 4'd1;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input bit h, input bit inj, input bit ord,
                       input int hx, input int hy, input int dx, input int dy, input int hot);
    f_valid = v; f_head = h; f_inject = inj; f_order = ord;
    here_x = CW'(hx); here_y = CW'(hy); dst_x = CW'(dx); dst_y = CW'(dy);
    loads = hot_load(hot);
  endtask

  // {inject, order_in, here_x, here_y, dst_x, dst_y, hot node, port, order}
  // Ports: 0 local, 1 east, 2 west, 3 north, 4 south.
  localparam int NV = 14;
  localparam logic [17:0] VECS [NV] = '{
    {1'b1, 1'b0, 2'd1, 2'd1, 2'd3, 2'd2, 4'd6,  3'd3, 1'b1}, // R5 hot on X-first path
    {1'b1, 1'b0, 2'd1, 2'd1, 2'd3, 2'd2, 4'd10, 3'd1, 1'b0}, // R5 hot on Y-first path
    {1'b1, 1'b0, 2'd1, 2'd1, 2'd3, 2'd2, 4'd0,  3'd1, 1'b0}, // R6 tie
    {1'b1, 1'b0, 2'd2, 2'd2, 2'd0, 2'd0, 4'd9,  3'd4, 1'b1}, // R3 south first
    {1'b1, 1'b0, 2'd2, 2'd2, 2'd0, 2'd0, 4'd6,  3'd2, 1'b0}, // R2 west first
    {1'b1, 1'b0, 2'd2, 2'd2, 2'd2, 2'd0, 4'd6,  3'd4, 1'b0}, // R6 same column
    {1'b1, 1'b0, 2'd1, 2'd3, 2'd3, 2'd3, 4'd0,  3'd1, 1'b0}, // R6 same row
    {1'b1, 1'b0, 2'd2, 2'd1, 2'd2, 2'd1, 4'd6,  3'd0, 1'b0}, // R4 home, injected
    {1'b0, 1'b1, 2'd1, 2'd1, 2'd3, 2'd2, 4'd10, 3'd3, 1'b1}, // R7 keeps Y-first
    {1'b0, 1'b0, 2'd1, 2'd1, 2'd3, 2'd2, 4'd6,  3'd1, 1'b0}, // R7 keeps X-first
    {1'b0, 1'b1, 2'd3, 2'd0, 2'd3, 2'd0, 4'd0,  3'd0, 1'b1}, // R4 home, transit
    {1'b0, 1'b1, 2'd3, 2'd2, 2'd0, 2'd2, 4'd0,  3'd2, 1'b1}, // R3 Y resolved, go west
    {1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd3, 4'd0,  3'd3, 1'b0}, // R2 X resolved, go north
    {1'b0, 1'b1, 2'd0, 2'd3, 2'd2, 2'd1, 4'd0,  3'd4, 1'b1}  // R3 south before east
  };

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    drive(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check(r_valid == 1'b0, "R10 reset valid", int'(r_valid), 0);
    rst_n = 1'b1;

    // Vector table: head at one negedge, result at the next.
    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VECS[i];
      @(negedge clk);
      drive(1'b1, 1'b1, v[17], v[16], int'(v[15:14]), int'(v[13:12]),
            int'(v[11:10]), int'(v[9:8]), int'(v[7:4]));
      @(negedge clk);
      check(r_valid == 1'b1, "R1 head valid", int'(r_valid), 1);
      check(r_port == v[3:1], "R2/R3 port (vector)", int'(r_port), int'(v[3:1]));
      check(r_order == v[0], "R5/R6/R7 order (vector)", int'(r_order), int'(v[0]));
      check(r_vc == v[0], "R8 vc class", int'(r_vc), int'(v[0]));
    end

    // R1: body flit and idle produce no valid.
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1, 1, 3, 2, 0);
    @(negedge clk);
    check(r_valid == 1'b0, "R1 body flit", int'(r_valid), 0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1, 1, 3, 2, 0);
    @(negedge clk);
    check(r_valid == 1'b0, "R1 idle", int'(r_valid), 0);

    // R9: load change while head is held flips decision without an edge.
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1, 1, 3, 2, 6);
    @(negedge clk);
    check(r_order == 1'b1, "R9 before load change", int'(r_order), 1);
    f_valid = 1'b0;
    loads = hot_load(10);
    #1;
    check(r_valid == 1'b1, "R9 still valid", int'(r_valid), 1);
    check(r_order == 1'b0, "R9 after load change", int'(r_order), 0);
    check(r_port == 3'd1, "R9 port follows", int'(r_port), 1);
    @(negedge clk);
    check(r_valid == 1'b0, "R1 single cycle", int'(r_valid), 0);

    // R10: asynchronous reset clears a held head.
    drive(1'b1, 1'b1, 1'b0, 1'b1, 0, 0, 3, 3, 0);
    @(negedge clk);
    check(r_valid == 1'b1, "R1 head before reset", int'(r_valid), 1);
    f_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(r_valid == 1'b0, "R10 reset clears", int'(r_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule